// File: doc/BRIEF.md
# Clock-synchronous serial port

This block moves 8-bit frames over a transmit data line, a receive data line and a shift clock line. It can generate the shift clock itself as master, using a two-stage divider made of a selectable power-of-two prescaler and a reloadable half-period counter. It can also act as slave and follow a clock that a peer drives. Data leaves on the falling clock edge and is sampled on the rising edge, least significant bit first. The clock idles high.

Software reaches the block through a small register port that takes one write or one read per cycle. A mode register turns the synchronous engine on and picks the clock source. A control register picks the prescaler tap, the handshake pin's role and the transmit driver style. A third register holds the enables and the status flags. A fourth holds the divider reload value, and a data address writes the transmit buffer and reads the receive buffer. The handshake pin works in one of two ways. As an input, it holds back transmission while the peer is not ready. As an output, it tells the peer that this side can take a frame.

Register map (3-bit address): 0 mode, 1 control, 2 enables/status, 3 divider reload `n`, 4 data.

Top module: `sync_serial_port`

## Requirements
- R1: The engine runs only while mode bits [2:0] read 3'b001 and mode bit 7 is 0. With any other mode value, a written frame never starts: status reads TE=1, TI=0, TxEPTY=1, and no output is enabled.
- R2: Mode bits 4 to 6 have no effect. Mode value 8'h71 behaves exactly like 8'h01.
- R3: With mode bit 3 = 0 the block is master: `sclk_oe`=1, and the clock idles high between frames. Each clock period lasts 2*(n+1)*P system cycles, where P is 1, 2^PS1, 2^PS2 or 2^PS3 for control bits [1:0] = 0 to 3. With mode bit 3 = 1, `sclk_oe`=0, the external clock is used and control bits [1:0] are ignored.
- R4: Bits go out least significant bit first. TxD changes only on the falling clock edge, and RxD is sampled on the rising edge.
- R5: A frame starts only when TE is 1, the transmit buffer is full (TI=0) and, with handshaking on and control bit 2 = 0, `hs_in` is low. On start, TI returns to 1 and TxEPTY drops to 0 until the eighth rising edge.
- R6: With control bit 4 = 1, handshaking is off: `hs_in` is ignored and `hs_oe` stays 0.
- R7: With control bit 4 = 0 and control bit 2 = 1, `hs_oe`=1. `hs_out` is low while RE=1 and RI=0, and goes high from frame completion until the receive buffer is read.
- R8: With RE=1, the eighth rising edge puts the frame into the receive buffer and sets RI. Reading address 4 returns the frame and clears RI.
- R9: If a frame completes while RI is still 1, OER is set and the buffer keeps its earlier contents. Clearing RE clears OER.
- R10: With control bit 5 = 1, TxD is open-drain: `txd_out`=0, and `txd_oe` is 1 only while the bit is 0.
- R11: As slave, the block shifts its transmit frame out and receives a frame on an externally driven clock. The frame is loaded as soon as it is written, so TxEPTY=0 before the first edge.
- R12: After reset, status reads 8'h22 (TI and TxEPTY set), and `sclk_oe`, `txd_oe` and `hs_oe` are 0.

Status bits at address 2: [0] TE, [1] TI, [2] RE, [3] RI, [4] OER, [5] TxEPTY. Writes to address 2 set TE from bit 0 and RE from bit 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (a read of address 4 clears RI) |
| addr | input | 3 | Register address |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data, combinational from addr |
| sclk_in | input | 1 | Shift clock from a peer (slave mode) |
| sclk_out | output | 1 | Generated shift clock |
| sclk_oe | output | 1 | Drive enable for the shift clock |
| txd_out | output | 1 | Transmit data value |
| txd_oe | output | 1 | Transmit data drive enable |
| rxd_in | input | 1 | Receive data |
| hs_in | input | 1 | Clear-to-send, active low |
| hs_out | output | 1 | Ready-to-receive, active low |
| hs_oe | output | 1 | Drive enable for the handshake pin |

## Verification
The bench loops the transmit line back to the receive line through a pull-up model. It measures the clock period for two prescaler taps and two reload values, because an off-by-one in the reload or the prescaler would show up directly as a wrong period. It holds clear-to-send high and checks that the clock never leaves its idle level, then checks that the handshake-off setting ignores the same level. It sends a second frame before reading the first: a design that overwrote the buffer on overrun would hand back the newer byte. It also runs the block as slave against a clock the bench drives, where a missing synchronizer stage or a swapped edge would corrupt both directions of the frame.

// File: rtl/sync_serial_port.sv
module sync_serial_port #(
  parameter int PS1  = 3,
  parameter int PS2  = 5,
  parameter int PS3  = 9,
  parameter int BRGW = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic       rd_en,
  input  logic [2:0] addr,
  input  logic [7:0] wr_data,
  output logic [7:0] rd_data,
  input  logic       sclk_in,
  output logic       sclk_out,
  output logic       sclk_oe,
  output logic       txd_out,
  output logic       txd_oe,
  input  logic       rxd_in,
  input  logic       hs_in,
  output logic       hs_out,
  output logic       hs_oe
);
  localparam int PW = (PS3 > 0) ? PS3 : 1;
  localparam logic [2:0] A_MODE = 3'd0, A_CTL = 3'd1, A_STAT = 3'd2, A_BRG = 3'd3, A_DATA = 3'd4;

  logic [7:0] mode_q, ctl_q, tx_buf, rx_buf, tx_sh, rx_sh;
  logic [BRGW-1:0] brg_q, brg_cnt;
  logic [PW-1:0] pre_cnt, pre_lim;
  logic [2:0] bit_cnt;
  logic te, re, ti, ri, oer, tx_active, txd_bit, sclk_r;
  logic s1, s2, s3, r1, r2;

  wire sync_ok = (mode_q[2:0] == 3'b001) && !mode_q[7];
  wire ext     = mode_q[3];
  wire hs_dir  = ctl_q[2];
  wire hs_off  = ctl_q[4];
  wire od      = ctl_q[5];

  always_comb begin
    case (ctl_q[1:0])
      2'd0:    pre_lim = '0;
      2'd1:    pre_lim = PW'((1 << PS1) - 1);
      2'd2:    pre_lim = PW'((1 << PS2) - 1);
      default: pre_lim = PW'((1 << PS3) - 1);
    endcase
  end

  wire master_run = sync_ok && !ext && tx_active;
  wire tick       = (pre_cnt == pre_lim);
  wire half_end   = master_run && tick && (brg_cnt == '0);
  wire listen     = sync_ok && ext && (tx_active || re);
  wire fall_e     = ext ? (listen && s3 && !s2) : (half_end && sclk_r);
  wire rise_e     = ext ? (listen && s2 && !s3) : (half_end && !sclk_r);
  wire rxd_s      = ext ? r2 : rxd_in;
  wire [7:0] rx_next = {rxd_s, rx_sh[7:1]};
  wire frame_end  = rise_e && (bit_cnt == 3'd7);
  wire cts_ok     = hs_off || hs_dir || !hs_in;
  wire start      = sync_ok && te && !ti && !tx_active && (bit_cnt == 3'd0) && cts_ok;
  wire rd_rx      = rd_en && (addr == A_DATA);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= 1'b1; s2 <= 1'b1; s3 <= 1'b1; r1 <= 1'b1; r2 <= 1'b1;
    end else begin
      s1 <= sclk_in; s2 <= s1; s3 <= s2;
      r1 <= rxd_in;  r2 <= r1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_cnt <= '0;
      brg_cnt <= '0;
      sclk_r  <= 1'b1;
    end else if (!master_run) begin
      pre_cnt <= '0;
      brg_cnt <= brg_q;
      sclk_r  <= 1'b1;
    end else begin
      pre_cnt <= tick ? '0 : pre_cnt + 1'b1;
      if (tick) begin
        if (brg_cnt == '0) begin
          brg_cnt <= brg_q;
          sclk_r  <= !sclk_r;
        end else begin
          brg_cnt <= brg_cnt - 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0; ctl_q <= '0; brg_q <= '0;
      tx_buf <= '0; rx_buf <= '0; tx_sh <= '0; rx_sh <= '0;
      te <= 1'b0; re <= 1'b0; ti <= 1'b1; ri <= 1'b0; oer <= 1'b0;
      tx_active <= 1'b0; txd_bit <= 1'b1; bit_cnt <= '0;
    end else begin
      if (wr_en) begin
        case (addr)
          A_MODE: mode_q <= wr_data;
          A_CTL:  ctl_q  <= wr_data;
          A_STAT: begin te <= wr_data[0]; re <= wr_data[2]; end
          A_BRG:  brg_q  <= wr_data[BRGW-1:0];
          A_DATA: if (ti) begin tx_buf <= wr_data; ti <= 1'b0; end
          default: ;
        endcase
      end
      if (start) begin
        tx_sh     <= tx_buf;
        ti        <= 1'b1;
        tx_active <= 1'b1;
      end
      if (fall_e && tx_active) begin
        txd_bit <= tx_sh[0];
        tx_sh   <= {1'b1, tx_sh[7:1]};
      end
      if (rise_e) begin
        rx_sh   <= rx_next;
        bit_cnt <= bit_cnt + 1'b1;
      end
      if (rd_rx) ri <= 1'b0;
      if (frame_end) begin
        tx_active <= 1'b0;
        if (re) begin
          if (ri) oer <= 1'b1;
          else begin
            rx_buf <= rx_next;
            ri     <= 1'b1;
          end
        end
      end
      if (!sync_ok) begin
        tx_active <= 1'b0;
        bit_cnt   <= '0;
      end
      if (!re) oer <= 1'b0;
    end
  end

  assign sclk_out = sclk_r;
  assign sclk_oe  = sync_ok && !ext;
  assign txd_out  = od ? 1'b0 : txd_bit;
  assign txd_oe   = sync_ok && (od ? !txd_bit : 1'b1);
  assign hs_oe    = sync_ok && hs_dir && !hs_off;
  assign hs_out   = !(re && !ri);

  always_comb begin
    case (addr)
      A_MODE:  rd_data = mode_q;
      A_CTL:   rd_data = ctl_q;
      A_STAT:  rd_data = {2'b00, !tx_active, oer, ri, re, ti, te};
      A_BRG:   rd_data = 8'(brg_q);
      A_DATA:  rd_data = rx_buf;
      default: rd_data = 8'h00;
    endcase
  end

  assert_cts_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_active) |-> $past(hs_off || hs_dir || !hs_in));
  assert_ti_on_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_active) |-> ti);
  assert_clk_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk_oe && !tx_active && !$past(tx_active)) |-> sclk_out);
  assert_ri_on_frame_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_end && re && !rd_rx) |=> ri);
  assert_overrun_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_end && re && ri && !rd_rx) |=> (oer && $stable(rx_buf)));
endmodule

// File: tb/tb_sync_serial_port.sv
module tb_sync_serial_port;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [2:0] addr = '0;
  logic [7:0] wr_data = '0, rd_data;
  logic tb_sclk = 1'b1, tb_rxd = 1'b1, loop = 1'b1, hs_in = 1'b1, mon_en = 1'b1;
  logic sclk_out, sclk_oe, txd_out, txd_oe, hs_out, hs_oe;
  int checks = 0, errors = 0, cyc = 0;
  bit done = 0;
  logic [7:0] exp_q[$];

  wire txd_line = txd_oe ? txd_out : 1'b1;
  wire rxd_in   = loop ? txd_line : tb_rxd;

  sync_serial_port dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wr_data(wr_data), .rd_data(rd_data), .sclk_in(tb_sclk), .sclk_out(sclk_out),
    .sclk_oe(sclk_oe), .txd_out(txd_out), .txd_oe(txd_oe), .rxd_in(rxd_in),
    .hs_in(hs_in), .hs_out(hs_out), .hs_oe(hs_oe)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; rd_en = 1'b1;
    #1 d = rd_data;
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic send(input logic [7:0] b);
    exp_q.push_back(b);
    wr(3'd4, b);
  endtask

  task automatic wait_bits(input logic [7:0] mask, input string req);
    logic [7:0] s;
    for (int i = 0; i < 20000; i++) begin
      rd(3'd2, s);
      if ((s & mask) == mask) return;
    end
    chk(req, 0, 1);
  endtask

  // monitor: captures master frames on the line and scores them against the queue
  logic prev_sclk = 1'b1;
  logic [7:0] mbyte = '0;
  int mbits = 0, fidx = 0, last_fall = 0, period = 0;
  always @(negedge clk) begin
    if (mon_en && rst_n) begin
      if (!sclk_out && prev_sclk) begin
        if (fidx == 1) period = cyc - last_fall;
        last_fall = cyc;
        fidx++;
      end
      if (sclk_out && !prev_sclk) begin
        mbyte = {txd_line, mbyte[7:1]};
        mbits++;
        if (mbits == 8) begin
          mbits = 0; fidx = 0;
          if (exp_q.size() == 0) chk("R4 unexpected frame", 1, 0);
          else chk("R4 bit order on line", mbyte, exp_q.pop_front());
        end
      end
    end
    prev_sclk = sclk_out;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    chk("watchdog expired", 1, 0);
    finish_run();
  end

  initial begin
    logic [7:0] s, d, cap, rxb;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R12 reset state
    rd(3'd2, s);           chk("R12 status after reset", s, 8'h22);
    chk("R12 sclk_oe", sclk_oe, 0); chk("R12 txd_oe", txd_oe, 0); chk("R12 hs_oe", hs_oe, 0);

    // R1 invalid mode holds the frame
    wr(3'd1, 8'h10); wr(3'd3, 8'h01); wr(3'd2, 8'h05);
    send(8'h5A);
    repeat (60) @(negedge clk);
    rd(3'd2, s);           chk("R1 mode 00 holds frame", s, 8'h25);
    chk("R1 no clock drive", sclk_oe, 0);
    wr(3'd0, 8'h81);
    repeat (60) @(negedge clk);
    rd(3'd2, s);           chk("R1 mode bit7 holds frame", s, 8'h25);

    // R2 bits 4..6 ignored; R3 period n=1 P=1; R8 receive
    wr(3'd0, 8'h71);
    wait_bits(8'h08, "R2 frame start with mode 71");
    chk("R3 period n=1 tap0", period, 4);
    rd(3'd4, d);           chk("R8 received byte", d, 8'h5A);
    rd(3'd2, s);           chk("R8 RI cleared by read", s, 8'h27);
    chk("R3 clock idle high", sclk_out, 1);

    // R3 prescaler tap 1 with n=2
    wr(3'd1, 8'h11); wr(3'd3, 8'h02);
    send(8'hC3);
    wait_bits(8'h08, "R3 frame tap1");
    chk("R3 period n=2 tap1", period, 48);
    rd(3'd4, d);           chk("R4 received C3", d, 8'hC3);
    chk("R10 push-pull drives", txd_oe, 1);

    // R5 CTS gate
    wr(3'd1, 8'h00); wr(3'd3, 8'h00);
    hs_in = 1'b1;
    send(8'h81);
    repeat (50) @(negedge clk);
    rd(3'd2, s);           chk("R5 CTS high blocks start", s, 8'h25);
    chk("R5 clock stays idle", sclk_out, 1);
    chk("R5 pin is input", hs_oe, 0);
    @(negedge clk); hs_in = 1'b0;
    wait_bits(8'h08, "R5 frame after CTS low");
    rd(3'd4, d);           chk("R5 received 81", d, 8'h81);
    @(negedge clk); hs_in = 1'b1;

    // R6 handshake off ignores CTS
    wr(3'd1, 8'h10);
    send(8'h3C);
    wait_bits(8'h08, "R6 frame with CTS high");
    rd(3'd4, d);           chk("R6 received 3C", d, 8'h3C);
    chk("R6 pin not driven", hs_oe, 0);

    // R7 RTS
    wr(3'd1, 8'h04);
    @(negedge clk);
    chk("R7 RTS driven", hs_oe, 1);
    chk("R7 RTS low when empty", hs_out, 0);
    send(8'hE7);
    wait_bits(8'h08, "R7 frame");
    @(negedge clk);
    chk("R7 RTS high while full", hs_out, 1);
    rd(3'd4, d);           chk("R7 received E7", d, 8'hE7);
    @(negedge clk);
    chk("R7 RTS low after read", hs_out, 0);

    // R9 overrun
    wr(3'd1, 8'h10);
    send(8'h11);
    wait_bits(8'h08, "R9 first frame");
    send(8'h22);
    wait_bits(8'h10, "R9 overrun flag");
    rd(3'd2, s);           chk("R9 status on overrun", s, 8'h3F);
    rd(3'd4, d);           chk("R9 old byte kept", d, 8'h11);
    wr(3'd2, 8'h01);
    rd(3'd2, s);           chk("R9 OER cleared by RE=0", s, 8'h23);
    wr(3'd2, 8'h05);

    // R10 open drain
    wr(3'd1, 8'h30);
    send(8'h96);
    wait_bits(8'h08, "R10 frame");
    rd(3'd4, d);           chk("R10 received 96", d, 8'h96);
    chk("R10 high bit released", txd_oe, 0);
    chk("R10 output value low", txd_out, 0);

    // R11 slave mode
    mon_en = 1'b0; loop = 1'b0;
    wr(3'd0, 8'h09); wr(3'd1, 8'h13);
    chk("R3 slave clock not driven", sclk_oe, 0);
    exp_q.push_back(8'hA5);
    wr(3'd4, 8'hA5);
    repeat (4) @(negedge clk);
    rd(3'd2, s);           chk("R11 frame loaded before clock", s, 8'h07);
    rxb = 8'h6B; cap = '0;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk); tb_sclk = 1'b0; tb_rxd = rxb[i];
      repeat (4) @(negedge clk);
      cap = {txd_line, cap[7:1]};
      tb_sclk = 1'b1;
      repeat (4) @(negedge clk);
    end
    repeat (6) @(negedge clk);
    chk("R11 slave transmit", cap, exp_q.pop_front());
    rd(3'd4, d);           chk("R11 slave receive", d, 8'h6B);
    rd(3'd2, s);           chk("R11 slave idle after frame", s, 8'h27);
    chk("R4 all frames scored", exp_q.size(), 0);

    finish_run();
  end
endmodule